// File: doc/BRIEF.md
# Control Register Move Side-Effect Unit

This block carries out the moves between a general register and the four paging control registers (indices 0, 2, 3 and 4). Each operation arrives as a ModR/M byte, a direction bit and a 32-bit source value, qualified by a valid strobe. The block decodes the byte and holds the four 32-bit registers. A move from a control register returns the selected register's value together with the general-register index that receives it. A move to a control register replaces the selected register.

A write also compares the old paging flags with the new ones in the same cycle. From that comparison the block raises one-cycle requests to the translation logic around it. The requests are: drop the non-global translation entries, drop every translation entry, or refill the cached page-directory pointers. When a host-environment flag is asserted, a move-to form is not carried out. The block raises an intercept instead. Malformed encodings raise an invalid-opcode pulse. Every result appears on the outputs one clock after the strobe.

Top module: `cr_move_unit`

## Requirements
- R1: After a synchronous active-low reset, all four control registers read as zero and every output is zero.
- R2: An encoding is legal when ModR/M bits 7:6 are 2'b11 and bits 5:3 hold 0, 2, 3 or 4. For a legal move-from (`op_to_cr`=0), one cycle after the strobe `rd_valid` is 1, `rd_data` holds the selected register and `rd_gpr` holds ModR/M bits 2:0. The host flag has no effect on move-from forms.
- R3: An illegal encoding that is not intercepted gives a one-cycle `bad_opcode` pulse. It changes no register and raises no other output.
- R4: A legal move-to (`op_to_cr`=1) with `host_mode`=0 replaces all 32 bits of the selected register, and a later move-from reads back that value. Without such a write, the registers hold their values.
- R5: Every write to register 3, even with an unchanged value, pulses `flush_nonglobal`.
- R6: `flush_global` pulses when a write to register 0 changes bit 0 or bit 31. It also pulses when a write to register 4 changes bit 4, 5 or 7. Writes to registers 2 and 3 never pulse it.
- R7: A write to register 4 that takes bit 5 (PAE) from 0 to 1 while register 0 bit 31 (PG) is 1 pulses `ptr_reload`.
- R8: A write to register 3 while PG and PAE are both 1 pulses `ptr_reload`.
- R9: A write to register 0 that takes PG from 0 to 1 while PAE is 1 pulses `ptr_reload`.
- R10: A move-to with `host_mode`=1 pulses `intercept` whatever the encoding. It raises no other output and changes no register.
- R11: Every output pulse lasts exactly one cycle. A cycle without the strobe produces all-zero outputs on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_to_cr | input | 1 | 1 = move to control register, 0 = move from |
| host_mode | input | 1 | Host-environment flag; move-to forms are intercepted |
| modrm | input | 8 | ModR/M byte of the operation |
| gpr_data | input | 32 | Source value for move-to forms |
| rd_valid | output | 1 | Read result present |
| rd_gpr | output | 3 | Destination general-register index |
| rd_data | output | 32 | Control register value read |
| flush_nonglobal | output | 1 | Drop non-global translation entries |
| flush_global | output | 1 | Drop all translation entries |
| ptr_reload | output | 1 | Refill page-directory pointer cache |
| intercept | output | 1 | Move-to trapped by host mode |
| bad_opcode | output | 1 | Illegal encoding |

## Verification
Two pairs of events can fall in the same cycle. A flag-changing write can request a global flush and a pointer reload at once. A write to register 3 can request a non-global flush and a pointer reload at once. Directed sequences provoke these cases. The first sets PAE with PG already 1. The second sets PG with PAE already 1. The third writes register 3 with both flags on. Random writes that toggle only the flag bits of the current value reach the same pairs again. Each cycle's whole output vector, read data and every pulse together, is compared with a model that tracks both the old flags and the new flags, so a missing pulse or an extra one shows up as a failure.

// File: rtl/cr_move_pkg.sv
// Package: shared constants and types of the control register move unit.
// Assumes 32-bit control registers and four architected slots.
package cr_move_pkg;
    localparam int CR_W    = 32;
    localparam int NUM_CR  = 4;
    localparam int SLOT_W  = $clog2(NUM_CR);
    localparam int PE_POS  = 0;
    localparam int PG_POS  = 31;
    localparam int PSE_POS = 4;
    localparam int PAE_POS = 5;
    localparam int PGE_POS = 7;
    localparam logic [CR_W-1:0] CR0_PAGE_MASK = (CR_W'(1) << PE_POS) | (CR_W'(1) << PG_POS);
    localparam logic [CR_W-1:0] CR4_PAGE_MASK =
        (CR_W'(1) << PSE_POS) | (CR_W'(1) << PAE_POS) | (CR_W'(1) << PGE_POS);

    // Storage slot of each architected register index
    typedef enum logic [SLOT_W-1:0] {
        SLOT_CR0 = 2'd0,
        SLOT_CR2 = 2'd1,
        SLOT_CR3 = 2'd2,
        SLOT_CR4 = 2'd3
    } cr_slot_e;

    // Side-effect requests raised by one write
    typedef struct packed {
        logic flush_ng;
        logic flush_all;
        logic ptr_load;
    } cr_fx_t;
endpackage

// File: rtl/cr_op_decode.sv
// Module: cr_op_decode
// Splits the ModR/M byte into the control register slot and the general
// register index, and flags encodings that name no register or use a
// memory form. Purely combinational.
module cr_op_decode
    import cr_move_pkg::*;
(
    input  logic [7:0]  modrm,
    output logic        legal,
    output cr_slot_e    slot,
    output logic [2:0]  gpr_idx
);
    logic reg_ok;

    // Map architected index to storage slot
    always_comb begin
        reg_ok = 1'b1;
        slot   = SLOT_CR0;
        case (modrm[5:3])
            3'd0:    slot = SLOT_CR0;
            3'd2:    slot = SLOT_CR2;
            3'd3:    slot = SLOT_CR3;
            3'd4:    slot = SLOT_CR4;
            default: reg_ok = 1'b0;
        endcase
    end

    // Register form only
    always_comb begin
        legal   = reg_ok && (modrm[7:6] == 2'b11);
        gpr_idx = modrm[2:0];
    end
endmodule

// File: rtl/cr_bank.sv
// Module: cr_bank
// Holds the control registers, one per slot. A single write port
// replaces a whole register. Synchronous active-low reset clears all.
module cr_bank
    import cr_move_pkg::*;
#(
    parameter int N = NUM_CR,
    parameter int W = CR_W,
    localparam int SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [SW-1:0]       wslot,
    input  logic [W-1:0]        wdata,
    output logic [N-1:0][W-1:0] cr_q
);
    for (genvar g = 0; g < N; g++) begin : g_slot
        // Update this slot when addressed by a write
        always_ff @(posedge clk) begin
            if (!rst_n)
                cr_q[g] <= '0;
            else if (we && (wslot == SW'(g)))
                cr_q[g] <= wdata;
        end
    end

    // R4: registers hold without a write
    a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(cr_q));
    // R4: written value lands in the addressed slot
    a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> cr_q[$past(wslot)] == $past(wdata));
endmodule

// File: rtl/cr_side_fx.sv
// Module: cr_side_fx
// Compares the current paging flags with an incoming write and works out
// which translation side effects the write requests. Combinational; the
// caller registers the result.
module cr_side_fx
    import cr_move_pkg::*;
(
    input  logic            we,
    input  cr_slot_e        slot,
    input  logic [CR_W-1:0] cur_cr0,
    input  logic [CR_W-1:0] cur_cr4,
    input  logic [CR_W-1:0] wdata,
    output cr_fx_t          fx
);
    logic            pg_now, pae_now;
    logic [CR_W-1:0] cr0_diff, cr4_diff;

    // Flag state before the write and bits that the write changes
    always_comb begin
        pg_now   = cur_cr0[PG_POS];
        pae_now  = cur_cr4[PAE_POS];
        cr0_diff = (cur_cr0 ^ wdata) & CR0_PAGE_MASK;
        cr4_diff = (cur_cr4 ^ wdata) & CR4_PAGE_MASK;
    end

    // Select requests by target slot
    always_comb begin
        fx = '0;
        if (we) begin
            case (slot)
                SLOT_CR0: begin
                    fx.flush_all = |cr0_diff;
                    fx.ptr_load  = pae_now && !pg_now && wdata[PG_POS];
                end
                SLOT_CR3: begin
                    fx.flush_ng = 1'b1;
                    fx.ptr_load = pae_now && pg_now;
                end
                SLOT_CR4: begin
                    fx.flush_all = |cr4_diff;
                    fx.ptr_load  = pg_now && !pae_now && wdata[PAE_POS];
                end
                default: fx = '0;
            endcase
        end
    end
endmodule

// File: rtl/cr_move_unit.sv
// Module: cr_move_unit (top)
// Executes moves to and from the paging control registers and raises
// one-cycle side-effect, intercept and invalid-opcode pulses. All results
// appear one clock after op_valid. Assumes one operation per cycle.
module cr_move_unit
    import cr_move_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic            op_to_cr,
    input  logic            host_mode,
    input  logic [7:0]      modrm,
    input  logic [31:0]     gpr_data,
    output logic            rd_valid,
    output logic [2:0]      rd_gpr,
    output logic [31:0]     rd_data,
    output logic            flush_nonglobal,
    output logic            flush_global,
    output logic            ptr_reload,
    output logic            intercept,
    output logic            bad_opcode
);
    logic                        legal;
    cr_slot_e                    slot;
    logic [2:0]                  gpr_idx;
    logic                        hit_icpt, hit_bad, do_wr, do_rd;
    logic [NUM_CR-1:0][CR_W-1:0] cr_q;
    cr_fx_t                      fx;

    cr_op_decode u_dec (
        .modrm   (modrm),
        .legal   (legal),
        .slot    (slot),
        .gpr_idx (gpr_idx)
    );

    // Classify the operation; intercept outranks the opcode check
    always_comb begin
        hit_icpt = op_valid && op_to_cr && host_mode;
        hit_bad  = op_valid && !hit_icpt && !legal;
        do_wr    = op_valid && op_to_cr && !host_mode && legal;
        do_rd    = op_valid && !op_to_cr && legal;
    end

    cr_bank #(.N(NUM_CR), .W(CR_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (do_wr),
        .wslot (slot),
        .wdata (gpr_data),
        .cr_q  (cr_q)
    );

    cr_side_fx u_fx (
        .we      (do_wr),
        .slot    (slot),
        .cur_cr0 (cr_q[SLOT_CR0]),
        .cur_cr4 (cr_q[SLOT_CR4]),
        .wdata   (gpr_data),
        .fx      (fx)
    );

    // Register read results and event pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid        <= 1'b0;
            rd_gpr          <= '0;
            rd_data         <= '0;
            flush_nonglobal <= 1'b0;
            flush_global    <= 1'b0;
            ptr_reload      <= 1'b0;
            intercept       <= 1'b0;
            bad_opcode      <= 1'b0;
        end else begin
            rd_valid        <= do_rd;
            rd_gpr          <= do_rd ? gpr_idx : 3'd0;
            rd_data         <= do_rd ? cr_q[slot] : '0;
            flush_nonglobal <= fx.flush_ng;
            flush_global    <= fx.flush_all;
            ptr_reload      <= fx.ptr_load;
            intercept       <= hit_icpt;
            bad_opcode      <= hit_bad;
        end
    end

    // R2: legal read yields a read result
    a_r2_read_result: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_to_cr && modrm[7:6] == 2'b11 && modrm[5:3] == 3'd0) |=> rd_valid);
    // R3: invalid opcode is silent otherwise
    a_r3_bad_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        bad_opcode |-> !(rd_valid || flush_nonglobal || flush_global || ptr_reload || intercept));
    // R5: any register 3 write flushes non-global entries
    a_r5_cr3_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_to_cr && !host_mode && modrm == {2'b11, 3'd3, modrm[2:0]}) |=> flush_nonglobal);
    // R8: a pointer reload leaves both paging flags set
    a_r8_ptr_needs_paging: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_reload |-> (cr_q[SLOT_CR0][PG_POS] && cr_q[SLOT_CR4][PAE_POS]));
    // R10: intercept blocks all other effects
    a_r10_intercept_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        intercept |-> !(rd_valid || flush_nonglobal || flush_global || ptr_reload || bad_opcode));
    // R10: intercepted move leaves registers untouched
    a_r10_no_update: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_to_cr && host_mode) |=> $stable(cr_q));
    // R11: no strobe, no output next cycle
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !(rd_valid || flush_nonglobal || flush_global || ptr_reload || intercept || bad_opcode));
endmodule

// File: tb/cr_move_unit_test.sv
module cr_move_unit_test;
    logic        clk = 1'b0;
    logic        rst_n, op_valid, op_to_cr, host_mode;
    logic [7:0]  modrm;
    logic [31:0] gpr_data;
    logic        rd_valid, flush_nonglobal, flush_global, ptr_reload, intercept, bad_opcode;
    logic [2:0]  rd_gpr;
    logic [31:0] rd_data;

    int n_run = 0;
    int n_fail = 0;
    logic [31:0] m_cr [4];

    always #2 clk = ~clk;

    cr_move_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_to_cr(op_to_cr),
        .host_mode(host_mode), .modrm(modrm), .gpr_data(gpr_data),
        .rd_valid(rd_valid), .rd_gpr(rd_gpr), .rd_data(rd_data),
        .flush_nonglobal(flush_nonglobal), .flush_global(flush_global),
        .ptr_reload(ptr_reload), .intercept(intercept), .bad_opcode(bad_opcode)
    );

    function automatic logic [40:0] outs();
        return {rd_valid, rd_gpr, rd_data, flush_nonglobal, flush_global,
                ptr_reload, intercept, bad_opcode};
    endfunction

    function automatic int slot_of(input logic [2:0] r);
        case (r)
            3'd0: return 0;
            3'd2: return 1;
            3'd3: return 2;
            3'd4: return 3;
            default: return -1;
        endcase
    endfunction

    task automatic check(input string tag, input logic [40:0] act, input logic [40:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one operation at a negedge, check the outputs one cycle later
    task automatic op(input bit to, input logic [7:0] mr, input logic [31:0] d, input bit hm);
        int s;
        logic legal, rv, fng, fall, ptr, icp, bad;
        logic [2:0] g;
        logic [31:0] rdv, old;
        string tag;
        s = slot_of(mr[5:3]);
        legal = (mr[7:6] == 2'b11) && (s >= 0);
        {rv, fng, fall, ptr, icp, bad} = '0;
        g = 3'd0; rdv = 32'd0; tag = "R4";
        if (to && hm) begin
            icp = 1'b1; tag = "R10";
        end else if (!legal) begin
            bad = 1'b1; tag = "R3";
        end else if (!to) begin
            rv = 1'b1; g = mr[2:0]; rdv = m_cr[s]; tag = "R2";
        end else begin
            old = m_cr[s];
            if (s == 2) begin
                fng = 1'b1; ptr = m_cr[3][5] && m_cr[0][31];
                tag = ptr ? "R8" : "R5";
            end else if (s == 0) begin
                fall = (old[0] ^ d[0]) || (old[31] ^ d[31]);
                ptr = m_cr[3][5] && !old[31] && d[31];
                tag = ptr ? "R9" : (fall ? "R6" : "R4");
            end else if (s == 3) begin
                fall = |((old ^ d) & 32'h0000_00B0);
                ptr = m_cr[0][31] && !old[5] && d[5];
                tag = ptr ? "R7" : (fall ? "R6" : "R4");
            end else begin
                tag = "R6";
            end
            m_cr[s] = d;
        end
        op_valid = 1'b1; op_to_cr = to; modrm = mr; gpr_data = d; host_mode = hm;
        @(negedge clk);
        check(tag, outs(), {rv, g, rdv, fng, fall, ptr, icp, bad});
    endtask

    function automatic logic [7:0] mrm(input logic [2:0] r, input logic [2:0] rm);
        return {2'b11, r, rm};
    endfunction

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) m_cr[i] = 32'd0;
        rst_n = 1'b0; op_valid = 1'b0; op_to_cr = 1'b0; host_mode = 1'b0;
        modrm = 8'd0; gpr_data = 32'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1", outs(), '0);
        // R1: every register reads zero after reset
        op(0, mrm(3'd0, 3'd1), 0, 0);
        op(0, mrm(3'd2, 3'd2), 0, 0);
        op(0, mrm(3'd3, 3'd3), 0, 0);
        op(0, mrm(3'd4, 3'd7), 0, 0);
        // R4/R6: plain writes and readback; register 2 never flushes
        op(1, mrm(3'd2, 3'd0), 32'hDEAD_BEEF, 0);
        op(0, mrm(3'd2, 3'd5), 0, 0);
        op(1, mrm(3'd0, 3'd0), 32'h0000_0001, 0);
        op(1, mrm(3'd0, 3'd0), 32'h0000_0F01, 0);
        // R5: register 3 writes, repeated value
        op(1, mrm(3'd3, 3'd1), 32'h1234_5000, 0);
        op(1, mrm(3'd3, 3'd1), 32'h1234_5000, 0);
        // R6: PAE set with PG clear gives global flush only
        op(1, mrm(3'd4, 3'd2), 32'h0000_0020, 0);
        // R9: set PG with PAE on -> flush and reload together
        op(1, mrm(3'd0, 3'd2), 32'h8000_0001, 0);
        // R8: register 3 write with both flags on
        op(1, mrm(3'd3, 3'd4), 32'h0000_A000, 0);
        // R7: clear then set PAE with PG on
        op(1, mrm(3'd4, 3'd2), 32'h0000_0000, 0);
        op(1, mrm(3'd4, 3'd2), 32'h0000_00A0, 0);
        // R3: bad index and memory form change nothing
        op(1, mrm(3'd1, 3'd0), 32'hFFFF_FFFF, 0);
        op(1, {2'b10, 3'd3, 3'd0}, 32'hFFFF_FFFF, 0);
        op(0, mrm(3'd5, 3'd0), 0, 0);
        op(0, mrm(3'd3, 3'd6), 0, 0);
        // R10: intercepted write, then readback; reads ignore host flag
        op(1, mrm(3'd4, 3'd0), 32'h0000_0000, 1);
        op(1, mrm(3'd7, 3'd0), 32'h0000_0000, 1);
        op(0, mrm(3'd4, 3'd3), 0, 1);
        // R11: idle cycle yields quiet outputs
        op_valid = 1'b0;
        @(negedge clk);
        check("R11", outs(), '0);
        // Random mix with flag-bit toggles
        for (int i = 0; i < 600; i++) begin
            logic [7:0] mr;
            logic [31:0] d;
            int s;
            bit to, hm;
            mr = 8'($urandom);
            if ($urandom_range(7) != 0) mr[7:6] = 2'b11;
            to = $urandom_range(1) == 1;
            hm = $urandom_range(7) == 0;
            s = slot_of(mr[5:3]);
            d = $urandom;
            if (s >= 0 && $urandom_range(1) == 1)
                d = m_cr[s] ^ ($urandom & 32'h8000_00B1);
            op(to, mr, d, hm);
            if ($urandom_range(9) == 0) begin
                op_valid = 1'b0;
                @(negedge clk);
                check("R11", outs(), '0);
            end
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule